// File: doc/BRIEF.md
# Peripheral Reset and Readiness Sequencer

This block brings a set of on-chip peripherals, one fabric-side DDR memory controller and up to `NUM_SER` serial transceiver blocks, out of reset after power-up. It runs on a free-running oscillator clock. It follows two software configuration phases: firmware raises a first flag once the controller and lane registers are written, and a second flag once the remaining link registers are written. Between and after those flags the sequencer releases the memory controller core reset. It releases each serial block's PHY reset and then its core reset, the core reset only once that block's PLL reports lock. It waits out a settling time for the external memory before declaring it usable.

The block gives a separate readiness flag for the memory side and for the serial side, plus one overall completion flag. A processor-side ready flag rises as soon as the sequence starts. An external reset output follows the power-on reset, the fabric reset, both, or neither, as a parameter selects. If a PLL in use loses lock once the sequence has completed, everything is pulled back to its reset state and the sequence runs again. Which peripherals are present, the settling time in microseconds and the clock rate in MHz are parameters.

Top module: `periph_init_seq`

## Requirements
- R1: All reset outputs are active low. While either reset input is low, every reset output is low and every ready flag is low. After both reset inputs go high, the processor-side ready flag rises on the third rising clock edge, with no configuration flag needed.
- R2: The memory controller core reset output stays low until the first-phase flag is seen. It goes high on the third rising edge after that flag rises.
- R3: Each used serial block's PHY reset goes high on the fourth edge after the first-phase flag rises. Its core reset goes high only after its PHY reset is high and its own PLL lock has been seen: three edges after the lock rises, or one edge after PHY release if the lock was already high.
- R4: The serial-released output is high exactly when every used serial block has its core reset released.
- R5: Memory ready rises `SETTLE_US*CLK_MHZ + 3` edges after the memory PLL lock rises, provided the second-phase flag has already been taken. While the lock is low the count does not advance. A lock drop during the count restarts it from zero.
- R6: Serial ready rises once the second-phase flag has been taken, the serial blocks are released, and every used lane reports PMA ready. It does not wait for memory ready.
- R7: Completion rises one edge after all used readiness flags are high, and never while a used readiness flag is low.
- R8: The external reset output is selected by `EXT_MODE`: 0 always high, 1 low while power-on reset is low, 2 low while the fabric reset is low, 3 low while either is low. It goes low without waiting for a clock edge.
- R9: After completion, loss of lock on any used PLL drops completion, both readiness flags, processor ready and every reset release on the third edge. The processor-side ready flag comes back one edge later, and the sequence then completes again.
- R10: A serial block not marked in `SER_USED` keeps both of its resets low. Its lock and PMA-ready inputs have no effect on completion or on the loss-of-lock restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running oscillator clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| fab_rst_n_i | input | 1 | Fabric reset, active low, asynchronous |
| mem_pll_lock_i | input | 1 | Memory-side PLL lock, asynchronous |
| ser_pll_lock_i | input | NUM_SER | Per serial block PLL lock, asynchronous |
| cfg_phase1_i | input | 1 | First configuration phase finished, asynchronous |
| cfg_phase2_i | input | 1 | Second configuration phase finished, asynchronous |
| ser_pma_ok_i | input | NUM_SER | Per lane PMA-ready status, asynchronous |
| mem_core_rst_n_o | output | 1 | Memory controller core reset, active low |
| ser_phy_rst_n_o | output | NUM_SER | Per serial block PHY reset, active low |
| ser_core_rst_n_o | output | NUM_SER | Per serial block core reset, active low |
| ser_released_o | output | 1 | All used serial blocks out of reset |
| mem_ready_o | output | 1 | External memory settled and usable |
| ser_ready_o | output | 1 | Serial blocks configured and usable |
| all_ready_o | output | 1 | Every used peripheral initialized |
| proc_ready_o | output | 1 | Processor-side logic may be accessed |
| ext_rst_n_o | output | 1 | External reset output, active low |

## Verification
A wrong sequencer state shows at the reset outputs within one or two edges. A stuck phase would hold a reset low past its expected edge, and a skipped phase would release one before its flag. The bench samples each release at the exact edge count, with a sample one edge earlier. A miscounted settling timer shows as memory ready rising off its edge: the bench checks both sides of that edge, after a lock interruption as well. A broken loss-of-lock path would leave completion high, which the bench sees three edges after dropping a lock.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG1,
        ST_CFG2,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       proc_rdy;
        logic       mem_core_rel;
        logic       phy_go;
        logic       mem_rdy;
        logic       ser_rdy;
        logic       all_rdy;
    } seq_regs_t;

endpackage

// File: rtl/rst_cond.sv
module rst_cond (
    input  logic clk_i,
    input  logic arst_n_i,
    output logic rst_n_o
);
    logic s1_q, s2_q;

    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= 1'b1;
            s2_q <= s1_q;
        end
    end

    assign rst_n_o = s2_q;
endmodule

// File: rtl/sync2.sv
module sync2 #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] a_q, b_q;
    logic [W-1:0] a_d, b_d;

    always_comb begin
        a_d = d_i;
        b_d = a_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            a_q <= a_d;
            b_q <= b_d;
        end
    end

    assign q_o = b_q;
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int LIMIT = 10000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (!run_i)
            cnt_d = '0;
        else if (cnt_q != LIM)
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == LIM);

    AST_TMR_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LIM);                                   // R5
    AST_TMR_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past(run_i));                 // R5
endmodule

// File: rtl/ser_lane_rel.sv
module ser_lane_rel (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic go_i,
    input  logic lock_i,
    output logic phy_rel_o,
    output logic core_rel_o
);
    logic phy_q, phy_d, core_q, core_d;

    always_comb begin
        if (clr_i) begin
            phy_d  = 1'b0;
            core_d = 1'b0;
        end else begin
            phy_d  = phy_q | go_i;
            core_d = core_q | (phy_q & lock_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phy_q  <= 1'b0;
            core_q <= 1'b0;
        end else begin
            phy_q  <= phy_d;
            core_q <= core_d;
        end
    end

    assign phy_rel_o  = phy_q;
    assign core_rel_o = core_q;

    AST_CORE_AFTER_PHY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_q |-> phy_q);                               // R3
    AST_CORE_RISE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(core_q) |-> $past(phy_q));                 // R3
endmodule

// File: rtl/periph_init_seq.sv
module periph_init_seq
    import seq_pkg::*;
#(
    parameter int                  NUM_SER   = 2,
    parameter logic [NUM_SER-1:0]  SER_USED  = '1,
    parameter bit                  MEM_USED  = 1'b1,
    parameter int                  SETTLE_US = 200,
    parameter int                  CLK_MHZ   = 50,
    parameter int                  EXT_MODE  = 3
) (
    input  logic               clk_i,
    input  logic               por_n_i,
    input  logic               fab_rst_n_i,
    input  logic               mem_pll_lock_i,
    input  logic [NUM_SER-1:0] ser_pll_lock_i,
    input  logic               cfg_phase1_i,
    input  logic               cfg_phase2_i,
    input  logic [NUM_SER-1:0] ser_pma_ok_i,
    output logic               mem_core_rst_n_o,
    output logic [NUM_SER-1:0] ser_phy_rst_n_o,
    output logic [NUM_SER-1:0] ser_core_rst_n_o,
    output logic               ser_released_o,
    output logic               mem_ready_o,
    output logic               ser_ready_o,
    output logic               all_ready_o,
    output logic               proc_ready_o,
    output logic               ext_rst_n_o
);
    localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
    localparam int SW         = 3 + 2 * NUM_SER;
    localparam bit ANY_SER    = |SER_USED;

    // reset conditioning: asynchronous assertion, synchronous release
    logic por_s_n, fab_s_n, sys_rst_n;

    rst_cond u_por (.clk_i(clk_i), .arst_n_i(por_n_i),     .rst_n_o(por_s_n));
    rst_cond u_fab (.clk_i(clk_i), .arst_n_i(fab_rst_n_i), .rst_n_o(fab_s_n));

    assign sys_rst_n = por_s_n & fab_s_n;

    generate
        if (EXT_MODE == 0) begin : g_ext_never
            assign ext_rst_n_o = 1'b1;
        end else if (EXT_MODE == 1) begin : g_ext_por
            assign ext_rst_n_o = por_s_n;
        end else if (EXT_MODE == 2) begin : g_ext_fab
            assign ext_rst_n_o = fab_s_n;
        end else begin : g_ext_any
            assign ext_rst_n_o = por_s_n & fab_s_n;
        end
    endgenerate

    // input synchronization
    logic [SW-1:0]      sync_raw, sync_out;
    logic               mem_lock_s, ph1_s, ph2_s;
    logic [NUM_SER-1:0] ser_lock_s, pma_s;

    assign sync_raw = {mem_pll_lock_i, cfg_phase1_i, cfg_phase2_i, ser_pll_lock_i, ser_pma_ok_i};

    sync2 #(.W(SW)) u_sync (
        .clk_i (clk_i),
        .rst_ni(sys_rst_n),
        .d_i   (sync_raw),
        .q_o   (sync_out)
    );

    assign {mem_lock_s, ph1_s, ph2_s, ser_lock_s, pma_s} = sync_out;

    // sequencer registers
    seq_regs_t regs_q, regs_d;

    // per serial block release
    logic [NUM_SER-1:0] phy_rel, core_rel;
    logic               lane_clr;

    assign lane_clr = (regs_d.st == ST_IDLE);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SER; gi++) begin : g_lane
            if (SER_USED[gi]) begin : g_used
                ser_lane_rel u_lane (
                    .clk_i     (clk_i),
                    .rst_ni    (sys_rst_n),
                    .clr_i     (lane_clr),
                    .go_i      (regs_q.phy_go),
                    .lock_i    (ser_lock_s[gi]),
                    .phy_rel_o (phy_rel[gi]),
                    .core_rel_o(core_rel[gi])
                );
            end else begin : g_unused
                assign phy_rel[gi]  = 1'b0;
                assign core_rel[gi] = 1'b0;
            end
        end
    endgenerate

    logic ser_rel_all, pma_all, locks_ok, tmr_done, tmr_run;

    assign ser_rel_all = ANY_SER && (&(core_rel | ~SER_USED));
    assign pma_all     = &(pma_s | ~SER_USED);
    assign locks_ok    = (!MEM_USED || mem_lock_s) && (&(ser_lock_s | ~SER_USED));
    assign tmr_run     = (regs_q.st == ST_WAIT) && regs_q.mem_core_rel && mem_lock_s;

    generate
        if (MEM_USED) begin : g_mem_tmr
            settle_timer #(.LIMIT(SETTLE_CYC)) u_tmr (
                .clk_i (clk_i),
                .rst_ni(sys_rst_n),
                .run_i (tmr_run),
                .done_o(tmr_done)
            );
        end else begin : g_no_tmr
            assign tmr_done = 1'b0;
        end
    endgenerate

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.st)
            ST_IDLE: begin
                regs_d          = '0;
                regs_d.st       = ST_CFG1;
                regs_d.proc_rdy = 1'b1;
            end
            ST_CFG1: begin
                if (ph1_s) begin
                    regs_d.st           = ST_CFG2;
                    regs_d.mem_core_rel = MEM_USED;
                    regs_d.phy_go       = ANY_SER;
                end
            end
            ST_CFG2: begin
                if (ph2_s) regs_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                regs_d.mem_rdy = regs_q.mem_rdy | (MEM_USED & tmr_done);
                regs_d.ser_rdy = regs_q.ser_rdy | (ANY_SER & ser_rel_all & pma_all);
                if ((!MEM_USED || regs_q.mem_rdy) && (!ANY_SER || regs_q.ser_rdy)) begin
                    regs_d.st      = ST_DONE;
                    regs_d.all_rdy = 1'b1;
                end
            end
            ST_DONE: begin
                if (!locks_ok) regs_d = '0;
            end
            default: regs_d = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge sys_rst_n) begin
        if (!sys_rst_n) regs_q <= '0;
        else            regs_q <= regs_d;
    end

    assign mem_core_rst_n_o = regs_q.mem_core_rel;
    assign ser_phy_rst_n_o  = phy_rel;
    assign ser_core_rst_n_o = core_rel;
    assign ser_released_o   = ser_rel_all;
    assign mem_ready_o      = regs_q.mem_rdy;
    assign ser_ready_o      = regs_q.ser_rdy;
    assign all_ready_o      = regs_q.all_rdy;
    assign proc_ready_o     = regs_q.proc_rdy;

    AST_IDLE_HOLDS_RESETS: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
        !proc_ready_o |-> (!mem_core_rst_n_o && ser_phy_rst_n_o == '0));            // R1
    AST_RELEASED_NEEDS_PHY: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
        ser_released_o |-> ((ser_phy_rst_n_o | ~SER_USED) == '1));                 // R4
    AST_DONE_NEEDS_PARTS: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
        all_ready_o |-> ((mem_ready_o || !MEM_USED) && (ser_ready_o || !ANY_SER)));  // R7
    AST_SER_RDY_RELEASED: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
        ser_ready_o |-> ser_released_o);                                             // R6
    AST_LOSS_RESTARTS: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
        $fell(all_ready_o) |-> !proc_ready_o);                                       // R9
    AST_UNUSED_HELD: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
        ((ser_core_rst_n_o & ~SER_USED) == '0));                                     // R10
endmodule

// File: tb/tb_periph_init_seq.sv
module tb_periph_init_seq;
    localparam int NS    = 2;
    localparam int S_US  = 2;
    localparam int C_MHZ = 50;
    localparam int L     = S_US * C_MHZ;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          por_n, fab_n, mem_lock, ph1, ph2;
    logic [NS-1:0] ser_lock, pma;

    logic          mem_core_rst_n, ser_rel, mem_rdy, ser_rdy, all_rdy, proc_rdy, ext_n;
    logic [NS-1:0] phy_n, core_n;
    logic [2:0]    ext_m;

    int checks = 0;
    int errors = 0;

    periph_init_seq #(
        .NUM_SER(NS), .SER_USED(2'b01), .MEM_USED(1'b1),
        .SETTLE_US(S_US), .CLK_MHZ(C_MHZ), .EXT_MODE(3)
    ) dut (
        .clk_i(clk), .por_n_i(por_n), .fab_rst_n_i(fab_n),
        .mem_pll_lock_i(mem_lock), .ser_pll_lock_i(ser_lock),
        .cfg_phase1_i(ph1), .cfg_phase2_i(ph2), .ser_pma_ok_i(pma),
        .mem_core_rst_n_o(mem_core_rst_n), .ser_phy_rst_n_o(phy_n),
        .ser_core_rst_n_o(core_n), .ser_released_o(ser_rel),
        .mem_ready_o(mem_rdy), .ser_ready_o(ser_rdy), .all_ready_o(all_rdy),
        .proc_ready_o(proc_rdy), .ext_rst_n_o(ext_n)
    );

    genvar gm;
    generate
        for (gm = 0; gm < 3; gm++) begin : g_mode
            logic          a, b, c, d, e, f, g;
            logic [NS-1:0] h, k;
            periph_init_seq #(
                .NUM_SER(NS), .SER_USED(2'b01), .MEM_USED(1'b1),
                .SETTLE_US(S_US), .CLK_MHZ(C_MHZ), .EXT_MODE(gm)
            ) u_m (
                .clk_i(clk), .por_n_i(por_n), .fab_rst_n_i(fab_n),
                .mem_pll_lock_i(mem_lock), .ser_pll_lock_i(ser_lock),
                .cfg_phase1_i(ph1), .cfg_phase2_i(ph2), .ser_pma_ok_i(pma),
                .mem_core_rst_n_o(a), .ser_phy_rst_n_o(h), .ser_core_rst_n_o(k),
                .ser_released_o(b), .mem_ready_o(c), .ser_ready_o(d),
                .all_ready_o(e), .proc_ready_o(f), .ext_rst_n_o(ext_m[gm])
            );
            assign g = 1'b0;
        end
    endgenerate

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic nedge(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        nedge(4);
        chk("R1 proc low in reset", proc_rdy, 0);
        chk("R1 mem core rst low in reset", mem_core_rst_n, 0);
        chk("R1 phy rst low in reset", phy_n, 0);
        chk("R1 all ready low in reset", all_rdy, 0);
        chk("R8 ext low in reset mode3", ext_n, 0);
        por_n = 1'b1; fab_n = 1'b1;
        nedge(2);
        chk("R1 proc not yet", proc_rdy, 0);
        nedge(1);
        chk("R1 proc ready third edge", proc_rdy, 1);
        chk("R2 mem core held before phase1", mem_core_rst_n, 0);
    endtask

    task automatic t_phase1;
        mem_lock = 1'b1;
        nedge(3);
        ph1 = 1'b1;
        nedge(2);
        chk("R2 mem core not yet", mem_core_rst_n, 0);
        nedge(1);
        chk("R2 mem core released", mem_core_rst_n, 1);
        chk("R3 phy not yet", phy_n, 0);
        nedge(1);
        chk("R3 phy lane0 released", phy_n[0], 1);
        chk("R10 unused lane phy held", phy_n[1], 0);
        nedge(5);
        chk("R3 core waits for lock", core_n[0], 0);
        chk("R4 released low without lock", ser_rel, 0);
        ser_lock[0] = 1'b1;
        nedge(2);
        chk("R3 core not yet after lock", core_n[0], 0);
        nedge(1);
        chk("R3 core released after lock", core_n[0], 1);
        chk("R4 released high", ser_rel, 1);
        chk("R10 unused lane core held", core_n[1], 0);
    endtask

    task automatic t_phase2;
        pma[0] = 1'b1;
        mem_lock = 1'b0;
        nedge(3);
        ph2 = 1'b1;
        nedge(20);
        chk("R5 no memory ready without lock", mem_rdy, 0);
        chk("R6 serial ready independent of memory", ser_rdy, 1);
        chk("R7 completion waits for memory", all_rdy, 0);
        mem_lock = 1'b1;
        nedge(50);
        mem_lock = 1'b0;
        nedge(5);
        mem_lock = 1'b1;
        nedge(L + 2);
        chk("R5 memory ready not before count", mem_rdy, 0);
        chk("R7 completion low before memory", all_rdy, 0);
        nedge(1);
        chk("R5 memory ready at count", mem_rdy, 1);
        chk("R7 completion one edge later pending", all_rdy, 0);
        nedge(1);
        chk("R7 completion high", all_rdy, 1);
    endtask

    task automatic t_unused_ignored;
        ser_lock[1] = 1'b1; pma[1] = 1'b1;
        nedge(4);
        ser_lock[1] = 1'b0; pma[1] = 1'b0;
        nedge(6);
        chk("R10 unused lock drop ignored", all_rdy, 1);
        chk("R10 unused core still held", core_n[1], 0);
    endtask

    task automatic t_lock_loss;
        bit seen;
        ser_lock[0] = 1'b0;
        nedge(2);
        chk("R9 completion still high", all_rdy, 1);
        nedge(1);
        chk("R9 completion dropped", all_rdy, 0);
        chk("R9 memory ready dropped", mem_rdy, 0);
        chk("R9 serial ready dropped", ser_rdy, 0);
        chk("R9 proc ready dropped", proc_rdy, 0);
        chk("R9 mem core reset reasserted", mem_core_rst_n, 0);
        chk("R9 phy reset reasserted", phy_n[0], 0);
        nedge(1);
        chk("R9 proc ready back", proc_rdy, 1);
        ser_lock[0] = 1'b1;
        seen = 1'b0;
        for (int k = 0; k < L + 60; k++) begin
            @(negedge clk);
            if (all_rdy) begin
                seen = 1'b1;
                break;
            end
        end
        chk("R9 sequence completes again", seen, 1);
    endtask

    task automatic t_ext_modes;
        fab_n = 1'b0;
        #1;
        chk("R8 mode3 fabric async", ext_n, 0);
        chk("R8 mode2 fabric", ext_m[2], 0);
        chk("R8 mode1 ignores fabric", ext_m[1], 1);
        chk("R8 mode0 never", ext_m[0], 1);
        chk("R1 ready drops on fabric reset", all_rdy, 0);
        nedge(2);
        fab_n = 1'b1;
        nedge(3);
        chk("R8 mode3 released", ext_n, 1);
        por_n = 1'b0;
        #1;
        chk("R8 mode3 por async", ext_n, 0);
        chk("R8 mode1 por", ext_m[1], 0);
        chk("R8 mode2 ignores por", ext_m[2], 1);
        chk("R8 mode0 never por", ext_m[0], 1);
        nedge(2);
        por_n = 1'b1;
        nedge(3);
        chk("R8 mode1 released", ext_m[1], 1);
    endtask

    initial begin
        por_n = 1'b0; fab_n = 1'b0; mem_lock = 1'b0; ph1 = 1'b0; ph2 = 1'b0;
        ser_lock = '0; pma = '0;
        t_reset();
        t_phase1();
        t_phase2();
        t_unused_ignored();
        t_lock_loss();
        t_ext_modes();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule